// File: doc/BRIEF.md
# Network Activity LED Selector

The block drives a single status LED from five network event indications: link in pass state, receive activity, receive activity that passed the node's address filter, transmit activity and collision. Each event has its own enable bit in a small control register. The LED output is registered and asserts in the cycle after any enabled event is seen.

Software reaches the control register through a plain address, write-enable and data bus. Reads are combinational and return the enable bits and the current LED state. The asynchronous hardware reset loads the default enables, with only transmit indication on. The soft reset and stop inputs leave the enables untouched, and the register stays writable while either input is high. Either input holds the LED low for the cycle that follows it.

Top module: `led_sel_top`

## Requirements
- R1: After hardware reset (rst_ni low), the enable field is 5'b00001 (transmit only), a read of the control register returns 8'h01, and led_o is 0.
- R2: Event and enable bits share one index: bit 0 transmit, bit 1 receive, bit 2 address-matched receive, bit 3 link pass, bit 4 collision. With an event's enable at 1 and that event high at a rising edge, led_o is 1 after that edge.
- R3: An event whose enable bit is 0 has no effect on led_o.
- R4: led_o after an edge equals the OR over all sources of (enable AND event) sampled at that edge. It is 0 when no enabled event is high.
- R5: A write (we_i high, addr_i equal to REG_ADDR) loads wdata_i[4:0] into the enable field at the rising edge. The new value reads back right after that edge.
- R6: Control register bits 6:5 are reserved. Writes to them are dropped and they always read 0.
- R7: Bit 7 of a control register read returns the current led_o. Writes to bit 7 have no effect.
- R8: soft_rst_i and stop_i do not change the enable field. A write made while either is high still takes effect.
- R9: If soft_rst_i or stop_i is high at a rising edge, led_o is 0 after that edge, whatever the events are.
- R10: A read at any address other than REG_ADDR returns 0. A write to such an address leaves the enable field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| soft_rst_i | input | 1 | Soft reset; keeps enables, quiets LED |
| stop_i | input | 1 | Stop command; keeps enables, quiets LED |
| evt_i | input | 5 | Event indications, bit order as in R2 |
| addr_i | input | ADDR_W (4) | Register address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| led_o | output | 1 | Registered LED indication |

## Verification
An event change or a soft reset/stop shows on led_o one edge after it is sampled. A write shows on rdata_o right after the edge that stores it. A write that changes an enable needs a second edge before it can affect led_o. The driver changes inputs 1 ns after a rising edge, lets exactly one edge pass, and then queues the expected value. The monitor compares that value at the following falling edge, before the driver moves again.

// File: rtl/led_sel_pkg.sv
package led_sel_pkg;
  localparam int NUM_SRC = 5;

  typedef enum int {
    SRC_TX   = 0,
    SRC_RX   = 1,
    SRC_RXM  = 2,
    SRC_LINK = 3,
    SRC_COL  = 4
  } src_e;

  localparam logic [NUM_SRC-1:0] EN_HW_DEFAULT = NUM_SRC'(1) << SRC_TX;
endpackage

// File: rtl/led_sel_cfg.sv
module led_sel_cfg
  import led_sel_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] en_o
);
  logic [NUM_SRC-1:0] en_q;

  // hardware reset only; soft reset and stop never reach this flop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= EN_HW_DEFAULT;
    else if (wr_i) en_q <= wdata_i;
  end

  assign en_o = en_q;
endmodule

// File: rtl/led_sel_merge.sv
module led_sel_merge
  import led_sel_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               quiet_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic               led_o
);
  logic [NUM_SRC-1:0] hit;
  logic               led_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign hit[g] = en_i[g] & evt_i[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      led_q <= 1'b0;
    else if (quiet_i) led_q <= 1'b0;
    else              led_q <= |hit;
  end

  assign led_o = led_q;
endmodule

// File: rtl/led_sel_rdmux.sv
module led_sel_rdmux
  import led_sel_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int REG_ADDR = 0
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic               led_i,
  output logic [DATA_W-1:0]  rdata_o
);
  localparam int RSV_W = DATA_W - NUM_SRC - 1;

  logic [DATA_W-1:0] word;
  assign word = {led_i, {RSV_W{1'b0}}, en_i};

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(REG_ADDR)) rdata_o = word;
  end
endmodule

// File: rtl/led_sel_top.sv
module led_sel_top
  import led_sel_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int REG_ADDR = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               soft_rst_i,
  input  logic               stop_i,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               led_o
);
  logic [NUM_SRC-1:0] en_q;
  logic               cfg_wr;
  logic               quiet;

  assign cfg_wr = we_i && (addr_i == ADDR_W'(REG_ADDR));
  assign quiet  = soft_rst_i | stop_i;

  led_sel_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cfg_wr),
    .wdata_i (wdata_i[NUM_SRC-1:0]),
    .en_o    (en_q)
  );

  led_sel_merge u_merge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .quiet_i (quiet),
    .en_i    (en_q),
    .evt_i   (evt_i),
    .led_o   (led_o)
  );

  led_sel_rdmux #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .REG_ADDR (REG_ADDR)
  ) u_rdmux (
    .addr_i  (addr_i),
    .en_i    (en_q),
    .led_i   (led_o),
    .rdata_o (rdata_o)
  );

  // reserved and status bits of wdata_i are dropped by design
  logic unused_wdata;
  assign unused_wdata = ^wdata_i[DATA_W-1:NUM_SRC];
endmodule

// File: rtl/led_sel_chk.sv
module led_sel_chk
  import led_sel_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int REG_ADDR = 0
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               soft_rst_i,
  input logic               stop_i,
  input logic [NUM_SRC-1:0] evt_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               we_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               led_o,
  input logic [NUM_SRC-1:0] en_i
);
  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  logic reg_hit;
  assign reg_hit = addr_i == ADDR_W'(REG_ADDR);

  // R4: LED tracks the enabled events sampled one edge earlier
  a_r4_led_or: assert property (@(posedge clk_i) disable iff (!rst_ni || !live_q)
    !$past(soft_rst_i || stop_i) |-> led_o == $past(|(en_i & evt_i)));

  // R9: soft reset or stop quiets the LED
  a_r9_quiet_led: assert property (@(posedge clk_i) disable iff (!rst_ni || !live_q)
    $past(soft_rst_i || stop_i) |-> !led_o);

  // R8, R10: enables move only on a write to the register address
  a_r8_en_hold: assert property (@(posedge clk_i) disable iff (!rst_ni || !live_q)
    !$past(we_i && reg_hit) |-> $stable(en_i));

  // R5: a register write lands in the enable field
  a_r5_write: assert property (@(posedge clk_i) disable iff (!rst_ni || !live_q)
    $past(we_i && reg_hit) |-> en_i == $past(wdata_i[NUM_SRC-1:0]));

  // R6, R7: reserved bits read zero, top bit mirrors the LED
  a_r6_rsv_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_hit |-> (rdata_o[DATA_W-2:NUM_SRC] == '0) && (rdata_o[DATA_W-1] == led_o));

  // R10: other addresses read zero
  a_r10_other_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_hit |-> rdata_o == '0);
endmodule

bind led_sel_top led_sel_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .REG_ADDR (REG_ADDR)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .soft_rst_i (soft_rst_i),
  .stop_i     (stop_i),
  .evt_i      (evt_i),
  .addr_i     (addr_i),
  .we_i       (we_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .led_o      (led_o),
  .en_i       (en_q)
);

// File: tb/led_sel_top_tb.sv
module led_sel_top_tb;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              soft_rst_i = 1'b0;
  logic              stop_i = 1'b0;
  logic [4:0]        evt_i = '1;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              we_i = 1'b0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [DATA_W-1:0] rdata_o;
  logic              led_o;

  always #5 clk_i = ~clk_i;

  led_sel_top u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .stop_i     (stop_i),
    .evt_i      (evt_i),
    .addr_i     (addr_i),
    .we_i       (we_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .led_o      (led_o)
  );

  typedef struct {
    string       tag;
    logic        exp_led;
    logic [7:0]  exp_rd;
  } item_t;

  item_t sb_q[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  // monitor: compare queued expectations at the falling edge
  always @(negedge clk_i) begin
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (led_o !== it.exp_led || rdata_o !== it.exp_rd) begin
        n_fail++;
        $display("FAIL %s: led=%0b rdata=%02h, expected led=%0b rdata=%02h",
                 it.tag, led_o, rdata_o, it.exp_led, it.exp_rd);
      end
    end
  end

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic expect_now(string tag, logic led, logic [7:0] rd);
    item_t it;
    it.tag = tag; it.exp_led = led; it.exp_rd = rd;
    sb_q.push_back(it);
    @(negedge clk_i);
    #1;
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    step();
    we_i = 1'b0; addr_i = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state with all events high
    repeat (3) @(posedge clk_i);
    #1;
    expect_now("R1 in reset", 1'b0, 8'h01);
    evt_i = '0;
    rst_ni = 1'b1;
    step();
    expect_now("R1 after reset", 1'b0, 8'h01);

    // R2: transmit lights LED by default
    evt_i = 5'b00001; step(); expect_now("R2 tx default", 1'b1, 8'h81);
    evt_i = '0;       step(); expect_now("R4 no events", 1'b0, 8'h01);

    // R3: disabled sources ignored
    evt_i = 5'b11110; step(); expect_now("R3 disabled sources", 1'b0, 8'h01);
    evt_i = '0;

    // R5: enable all
    wr('0, 8'h1F); expect_now("R5 write all", 1'b0, 8'h1F);
    for (int i = 0; i < 5; i++) begin
      evt_i = 5'(1) << i; step();
      expect_now($sformatf("R2 source %0d", i), 1'b1, 8'h9F);
      evt_i = '0; step();
      expect_now("R4 idle", 1'b0, 8'h1F);
    end

    // R6, R7: reserved and status bits on write
    wr('0, 8'hE4); expect_now("R6 reserved dropped", 1'b0, 8'h04);
    evt_i = 5'b00100; step(); expect_now("R7 status bit", 1'b1, 8'h84);
    evt_i = '0; step();

    // R4: OR of rx and collision
    wr('0, 8'h12);
    evt_i = 5'b10000; step(); expect_now("R4 collision", 1'b1, 8'h92);
    evt_i = 5'b00010; step(); expect_now("R4 receive", 1'b1, 8'h92);
    evt_i = 5'b01101; step(); expect_now("R4 only disabled", 1'b0, 8'h12);
    evt_i = '0;

    // R8: soft reset / stop keep enables, writes still apply
    soft_rst_i = 1'b1; step(); expect_now("R8 soft keeps", 1'b0, 8'h12);
    soft_rst_i = 1'b0; stop_i = 1'b1; step(); expect_now("R8 stop keeps", 1'b0, 8'h12);
    stop_i = 1'b0;
    soft_rst_i = 1'b1; wr('0, 8'h08); soft_rst_i = 1'b0;
    expect_now("R8 write during soft", 1'b0, 8'h08);

    // R9: quiet LED with link active
    evt_i = 5'b01000; step(); expect_now("R2 link", 1'b1, 8'h88);
    soft_rst_i = 1'b1; step(); expect_now("R9 soft quiet", 1'b0, 8'h08);
    soft_rst_i = 1'b0; step(); expect_now("R9 soft release", 1'b1, 8'h88);
    stop_i = 1'b1; step(); expect_now("R9 stop quiet", 1'b0, 8'h08);
    stop_i = 1'b0; step(); expect_now("R9 stop release", 1'b1, 8'h88);

    // R10: other address
    wr(4'd1, 8'h1F);
    addr_i = 4'd1; #1; expect_now("R10 other read", 1'b1, 8'h00);
    addr_i = '0;   #1; expect_now("R10 other write ignored", 1'b1, 8'h88);

    step();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule